// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers up to 32 interrupt inputs and drives one active-low request line toward a processor. Each input has its own control word. The control word picks how the input is sensed (low level, high level, falling edge or rising edge) and gives it a priority from 0 to 7. Software sees the controller through a 32-bit register port. The port has per-source control words, status views, and write-one command registers. Those commands enable or disable sources, set or clear a pending source by software, and end service.

Servicing is a two-step handshake. The processor reads the encoding register and gets back the winning source number times four. That read takes the source into service and lets the request line drop. While the source is in service, no new request is raised. Any write to the end-of-service register releases arbitration, and the request line asserts again if anything enabled is still pending.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After a synchronous reset, `irq_n` is 1, the enable register (0x114) reads 0, every control word reads 0 (low-level sense, priority 0) and no source is in service (0x104 reads 0).
- R2: The control word of source n sits at byte offset 4*n. Bits [7:6] hold the sense type (00 low level, 01 high level, 10 falling edge, 11 rising edge). Bits [2:0] hold the priority. All other bits read back as 0.
- R3: A level-sensed source shows in the raw status register (0x100) while its input is at the active level. Low-level inputs are inverted, so an input of 0 reads as 1.
- R4: An edge-sensed source latches a pending bit on its selected edge and keeps it after the input returns. Acknowledging that source clears the bit.
- R5: Writing to 0x120 enables each source whose data bit is 1. Writing to 0x124 disables each source whose data bit is 1. Zero bits leave sources unchanged. The enable register 0x114 has bit n = 1 for an enabled source. The status register 0x108 reads raw status AND enable.
- R6: Among pending, enabled sources, the highest priority value wins. On a priority tie, the lowest source number wins.
- R7: When no source is in service, reading 0x10C returns the winner's number times 4 and takes that source into service. `irq_n` then returns to 1. Reading 0x110 afterwards returns the plain number of that source.
- R8: While a source is in service, `irq_n` stays 1 whatever is pending. Any write to 0x130 ends service, and `irq_n` falls again if an enabled source is pending.
- R9: Writing to 0x128 sets the pending bit of each source whose data bit is 1. Writing to 0x12C clears it. Level inputs still show while they are active.
- R10: The active register 0x104 is one-hot for the source in service and 0 otherwise. Bit 0 of the output status register 0x118 is 1 while the request is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | N_SRC | Interrupt inputs |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| irq_n | output | 1 | Active-low interrupt request, registered |

## Verification
The bench builds the block with its defaults: 32 sources, 3-bit priorities and a 9-bit address. With those defaults, every offset up to the end-of-service register is reachable. It also lets the whole priority range and ties between distant source numbers be exercised. The bench uses each sense type. It drives software set and clear, and enables and disables with mixed bit patterns. It walks a three-source priority chain through acknowledge and end of service, and confirms that the request is held off until service ends.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_FALL = 2'b10,
    TRIG_RISE = 2'b11
  } trig_e;

  localparam int OFF_RAW    = 'h100;
  localparam int OFF_ACTIVE = 'h104;
  localparam int OFF_STATUS = 'h108;
  localparam int OFF_ENCODE = 'h10C;
  localparam int OFF_NUMBER = 'h110;
  localparam int OFF_ENABLE = 'h114;
  localparam int OFF_OUTST  = 'h118;
  localparam int OFF_EN_CMD = 'h120;
  localparam int OFF_DIS_CMD = 'h124;
  localparam int OFF_SET_CMD = 'h128;
  localparam int OFF_CLR_CMD = 'h12C;
  localparam int OFF_EOS    = 'h130;
endpackage

// File: rtl/irqc_src.sv
module irqc_src
  import irqc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  in_i,
  input  trig_e trig_i,
  input  logic  sw_set_i,
  input  logic  sw_clr_i,
  input  logic  ack_i,
  output logic  pend_o
);
  logic s_q, s_p, latch_q, edge_hit, lvl_act, is_level;

  assign is_level = (trig_i == TRIG_LOW) || (trig_i == TRIG_HIGH);
  assign lvl_act  = (trig_i == TRIG_LOW) ? ~s_q : s_q;

  always_comb begin
    case (trig_i)
      TRIG_RISE: edge_hit = s_q & ~s_p;
      TRIG_FALL: edge_hit = ~s_q & s_p;
      default:   edge_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_q     <= 1'b0;
      s_p     <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      s_q     <= in_i;
      s_p     <= s_q;
      latch_q <= (latch_q & ~ack_i & ~sw_clr_i) | sw_set_i | edge_hit;
    end
  end

  assign pend_o = latch_q | (is_level & lvl_act);

  // R4: an acknowledge with no new edge or set leaves the latch clear
  a_r4_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !sw_set_i && !edge_hit) |=> !latch_q);
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb #(
  parameter int N_SRC  = 32,
  parameter int PRIO_W = 3,
  localparam int IDW   = $clog2(N_SRC)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [N_SRC-1:0]              req_i,
  input  logic [N_SRC-1:0][PRIO_W-1:0]  prio_i,
  output logic                          win_valid_o,
  output logic [IDW-1:0]                win_id_o
);
  logic [PRIO_W-1:0] best;

  // Scan from high index to low with >= so ties settle on the lowest index.
  always_comb begin
    win_valid_o = 1'b0;
    win_id_o    = '0;
    best        = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_i[i] && (!win_valid_o || prio_i[i] >= best)) begin
        win_valid_o = 1'b1;
        win_id_o    = IDW'(i);
        best        = prio_i[i];
      end
    end
  end

  // R6: the winner is always a requesting source
  a_r6_win_requests: assert property (@(posedge clk) disable iff (rst)
    win_valid_o |-> req_i[win_id_o]);
  // R6: a valid winner exists whenever any source requests
  a_r6_any_wins: assert property (@(posedge clk) disable iff (rst)
    (req_i != '0) |-> win_valid_o);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq_n
);
  localparam int IDW = $clog2(N_SRC);

  trig_e                         trig_q [N_SRC];
  logic [N_SRC-1:0][PRIO_W-1:0]  prio_q;
  logic [N_SRC-1:0]              en_q, pend, req, ack_vec, set_vec, clr_vec;
  logic                          busy_q, busy_n, win_valid;
  logic [IDW-1:0]                win_id, cur_id;
  logic                          ctl_hit, hit_enc, hit_eos, ack, eos;
  logic [IDW-1:0]                ctl_idx;
  logic [31:0]                   rd_mux;

  assign ctl_idx = addr[IDW+1:2];
  assign ctl_hit = (addr[1:0] == 2'b00) && (addr[ADDR_W-1:2] < (ADDR_W-2)'(N_SRC));
  assign hit_enc = (addr == ADDR_W'(OFF_ENCODE));
  assign hit_eos = (addr == ADDR_W'(OFF_EOS));
  assign ack     = rd_en && hit_enc && win_valid && !busy_q;
  assign eos     = wr_en && hit_eos;
  assign busy_n  = eos ? 1'b0 : (ack ? 1'b1 : busy_q);

  assign set_vec = (wr_en && addr == ADDR_W'(OFF_SET_CMD)) ? wdata[N_SRC-1:0] : '0;
  assign clr_vec = (wr_en && addr == ADDR_W'(OFF_CLR_CMD)) ? wdata[N_SRC-1:0] : '0;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign ack_vec[g] = ack && (win_id == IDW'(g));
    irqc_src u_src (
      .clk      (clk),
      .rst      (rst),
      .in_i     (src_i[g]),
      .trig_i   (trig_q[g]),
      .sw_set_i (set_vec[g]),
      .sw_clr_i (clr_vec[g]),
      .ack_i    (ack_vec[g]),
      .pend_o   (pend[g])
    );
  end

  assign req = pend & en_q;

  irqc_arb #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
    .clk         (clk),
    .rst         (rst),
    .req_i       (req),
    .prio_i      (prio_q),
    .win_valid_o (win_valid),
    .win_id_o    (win_id)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_SRC; i++) trig_q[i] <= TRIG_LOW;
      prio_q <= '0;
      en_q   <= '0;
      busy_q <= 1'b0;
      cur_id <= '0;
      irq_n  <= 1'b1;
    end else begin
      if (wr_en && ctl_hit) begin
        trig_q[ctl_idx] <= trig_e'(wdata[7:6]);
        prio_q[ctl_idx] <= wdata[PRIO_W-1:0];
      end
      if (wr_en && addr == ADDR_W'(OFF_EN_CMD))  en_q <= en_q | wdata[N_SRC-1:0];
      if (wr_en && addr == ADDR_W'(OFF_DIS_CMD)) en_q <= en_q & ~wdata[N_SRC-1:0];
      if (ack) cur_id <= win_id;
      busy_q <= busy_n;
      irq_n  <= ~(win_valid & ~busy_n);
    end
  end

  always_comb begin
    rd_mux = '0;
    if (ctl_hit) begin
      rd_mux[7:6]        = trig_q[ctl_idx];
      rd_mux[PRIO_W-1:0] = prio_q[ctl_idx];
    end else begin
      case (addr)
        ADDR_W'(OFF_RAW):    rd_mux[N_SRC-1:0] = pend;
        ADDR_W'(OFF_ACTIVE): if (busy_q) rd_mux[cur_id] = 1'b1;
        ADDR_W'(OFF_STATUS): rd_mux[N_SRC-1:0] = req;
        ADDR_W'(OFF_ENCODE): rd_mux[IDW+1:2] = win_id;
        ADDR_W'(OFF_NUMBER): rd_mux[IDW-1:0] = cur_id;
        ADDR_W'(OFF_ENABLE): rd_mux[N_SRC-1:0] = en_q;
        ADDR_W'(OFF_OUTST):  rd_mux[0] = ~irq_n;
        default:             rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R1: reset leaves the request line idle
  a_r1_reset_idle: assert property (@(posedge clk) rst |=> irq_n);
  // R8: no request while a source is in service
  a_r8_hold_off: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> irq_n);
  // R7: an acknowledge takes the source into service
  a_r7_ack_takes: assert property (@(posedge clk) disable iff (rst)
    (ack && !eos) |=> busy_q);
  // R8: end of service releases arbitration
  a_r8_eos_release: assert property (@(posedge clk) disable iff (rst)
    eos |=> !busy_q);
  // R5: enable command sets every written one
  a_r5_enable_sets: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(OFF_EN_CMD)) |=>
      ((en_q & $past(wdata[N_SRC-1:0])) == $past(wdata[N_SRC-1:0])));
  // R5: disable command clears every written one
  a_r5_disable_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(OFF_DIS_CMD)) |=>
      ((en_q & $past(wdata[N_SRC-1:0])) == '0));
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [N-1:0] src_i = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_n;

  int n_tests = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_pipe = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst(rst), .src_i(src_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n)
  );

  always @(posedge clk) rd_pipe <= rd_en;

  // Scoreboard monitor: compares each returned read against the queue head
  always @(negedge clk) begin
    if (rd_pipe && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_tests++;
      if (rdata !== e) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", t, rdata, e);
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 9'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string t);
    @(negedge clk);
    rd_en = 1'b1; addr = 9'(a);
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string t);
    settle();
    n_tests++;
    if (irq_n !== e) begin
      n_fail++;
      $display("FAIL %s: irq_n got %b expected %b", t, irq_n, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk_irq(1'b1, "R1 irq_n idle");
    rd('h114, 32'h0, "R1 enable reg");
    rd('h14, 32'h0, "R1 ctl word");
    rd('h104, 32'h0, "R10 active idle");
    settle();
    rd('h100, 32'hFFFF_FFFF, "R3 low-level inputs at 0 read raw 1");
    // all sources high level, priority 0
    for (int i = 0; i < N; i++) wr(4*i, 32'h40);
    settle();
    rd('h100, 32'h0, "R3 high-level inputs at 0");
    wr('h0C, 32'hFFFF_FFFF);
    rd('h0C, 32'h0000_00C7, "R2 ctl bits readback");
    wr('h0C, 32'h40);
    // R3 level sensing
    wr('h10, 32'h45);
    wr('h24, 32'h00);
    src_i[4] = 1'b1;
    settle();
    rd('h100, (32'h1 << 4) | (32'h1 << 9), "R3 high and low level raw");
    wr('h24, 32'h40);
    // R5 enable / disable
    wr('h120, 32'h0000_0210);
    rd('h114, 32'h0000_0210, "R5 enable write-one");
    wr('h124, 32'h0000_0200);
    rd('h114, 32'h0000_0010, "R5 disable write-one");
    rd('h108, 32'h0000_0010, "R5 status = raw & enable");
    // R7 / R8 handshake
    chk_irq(1'b0, "R7 request asserted");
    rd('h10C, 32'd16, "R7 encode returns id*4");
    chk_irq(1'b1, "R7 request drops after read");
    rd('h110, 32'd4, "R7 source number");
    rd('h104, 32'h1 << 4, "R10 active one-hot");
    rd('h118, 32'h0, "R10 output status idle");
    chk_irq(1'b1, "R8 held while in service");
    wr('h130, 32'h0);
    chk_irq(1'b0, "R8 re-raised after end of service");
    rd('h118, 32'h1, "R10 output status asserted");
    src_i[4] = 1'b0;
    chk_irq(1'b1, "R3 level drop removes request");
    // R4 rising edge
    wr('h28, 32'hC2);
    wr('h2C, 32'h81);
    wr('h120, 32'h0000_0C00);
    src_i[10] = 1'b1;
    repeat (2) @(negedge clk);
    src_i[10] = 1'b0;
    settle();
    rd('h100, 32'h1 << 10, "R4 rising edge latched");
    rd('h10C, 32'd40, "R4 encode rising source");
    settle();
    rd('h100, 32'h0, "R4 ack clears edge pending");
    wr('h130, 32'h0);
    chk_irq(1'b1, "R4 no request after edge served");
    // R4 falling edge, R9 clear
    src_i[11] = 1'b1;
    settle();
    rd('h100, 32'h0, "R4 rising input on falling source");
    src_i[11] = 1'b0;
    settle();
    rd('h100, 32'h1 << 11, "R4 falling edge latched");
    wr('h12C, 32'h1 << 11);
    settle();
    rd('h100, 32'h0, "R9 clear command");
    chk_irq(1'b1, "R9 cleared source no request");
    // R9 set on masked source
    wr('h128, 32'h1 << 20);
    settle();
    rd('h100, 32'h1 << 20, "R9 set command");
    rd('h108, 32'h0, "R5 masked source not in status");
    chk_irq(1'b1, "R5 masked source no request");
    wr('h12C, 32'h1 << 20);
    // R6 arbitration
    wr('h1C, 32'h43);
    wr('h30, 32'h46);
    wr('h3C, 32'h46);
    wr('h120, (32'h1 << 7) | (32'h1 << 12) | (32'h1 << 15));
    wr('h128, (32'h1 << 7) | (32'h1 << 12) | (32'h1 << 15));
    chk_irq(1'b0, "R6 request raised");
    rd('h10C, 32'd48, "R6 tie lowest index wins");
    chk_irq(1'b1, "R8 pending held off in service");
    wr('h130, 32'h0);
    chk_irq(1'b0, "R8 re-raise for next");
    rd('h10C, 32'd60, "R6 next equal priority");
    wr('h130, 32'h0);
    settle();
    rd('h10C, 32'd28, "R6 lower priority last");
    wr('h130, 32'h0);
    chk_irq(1'b1, "R6 chain drained");
    settle();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule